// File: doc/BRIEF.md
# Keyed Flash Write/Erase Controller

This block sits between the byte-wide data-space write port of a small CPU and an on-chip flash array. A control register steers data-space writes either to ordinary RAM (the default) or to flash, and a second control bit turns the next flash-directed write into a page erase. Before any program or erase is started, software has to write a two-byte unlock sequence into a key port. Each unlock allows exactly one operation. A bad key locks flash out until the next device reset.

Programming stores the bitwise AND of the existing byte and the new byte, so it can only clear bits. An erase walks a whole 512-byte page, writing 0xFF one byte per cycle. Both operations are timed in hardware and hold a busy flag for their whole duration. Requests aimed at the reserved top kilobyte are rejected and flagged. Any flash attempt made while the supply monitor is disabled becomes a reset request. Interrupts that arrive during an operation are held and delivered once the operation has finished.

Top module: `flash_wr_ctrl`

## Requirements
- R1: Flash operations are unlocked by a key write of 0xA5 followed by a key write of 0xF1. Any number of idle cycles may lie between the two. A flash-directed write made without an unlock changes nothing.
- R2: One program or erase, or one rejected reserved-range attempt, consumes the unlock. The following flash-directed write is dropped until a new sequence arrives.
- R3: A wrong first key, a wrong second key, or a key write while unlocked puts the controller into lockout. Lockout blocks every flash operation until rst_ni is asserted.
- R4: A control write sets the write-enable bit from ctl_wdata_i[0] and the erase-select bit from ctl_wdata_i[1]. Both bits are 0 after reset, and both keep their values until the next control write. They are readable on wen_o and erase_sel_o.
- R5: With write-enable at 0, a data-space write drives ram_we_o in the same cycle. With write-enable at 1, it does not reach RAM.
- R6: A data-space read always drives ram_re_o, whatever the write-enable bit is.
- R7: A program writes old AND new to the addressed byte, in the last of PROG_CYCLES (8) busy cycles.
- R8: With erase-select at 1, an unlocked write erases the 512-byte page containing its address to 0xFF. The erase writes one byte per cycle, holds busy for 512 cycles, ignores the written data and leaves other pages untouched.
- R9: A flash attempt at an address from 0x7C00 to 0x7FFF produces a one-cycle rsv_err_o pulse and no array write.
- R10: A flash attempt while vdd_mon_en_i is low produces a one-cycle flash_err_rst_o pulse and no array write. This check takes precedence over the reserved-range check and over the key state, and it leaves the key state unchanged.
- R11: busy_o is 1 for the whole operation. Flash-directed writes that arrive while busy are ignored and do not consume the unlock.
- R12: While busy, irq_o is 0 and incoming interrupt bits are held. When busy ends, the held bits appear on irq_o for one cycle. When not busy, irq_i passes straight through to irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 2 | Bit 0 is write-enable, bit 1 is erase-select |
| wen_o | output | 1 | Current write-enable bit |
| erase_sel_o | output | 1 | Current erase-select bit |
| key_wr_i | input | 1 | Key port write strobe |
| key_wdata_i | input | 8 | Key byte |
| cpu_wr_i | input | 1 | Data-space write strobe |
| cpu_rd_i | input | 1 | Data-space read strobe |
| cpu_addr_i | input | 15 | Data-space address |
| cpu_wdata_i | input | 8 | Data-space write data |
| ram_we_o | output | 1 | RAM write strobe |
| ram_re_o | output | 1 | RAM read strobe |
| ram_addr_o | output | 15 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| vdd_mon_en_i | input | 1 | Supply monitor enabled |
| fl_rdata_i | input | 8 | Flash array read data at fl_addr_o |
| fl_we_o | output | 1 | Flash array byte write strobe |
| fl_addr_o | output | 15 | Flash array address |
| fl_wdata_o | output | 8 | Flash array write data |
| busy_o | output | 1 | Operation in progress |
| rsv_err_o | output | 1 | Reserved-range rejection pulse |
| flash_err_rst_o | output | 1 | Flash-error reset request pulse |
| irq_i | input | 4 | Interrupt requests in |
| irq_o | output | 4 | Interrupt requests out |

## Verification
The hardest situation to reach is a write that would be a fully valid flash request, except that it arrives while busy is high. To create it, the stimulus starts an erase and then, during the 512 busy cycles, sends a fresh unlock and a program write to another page. After the erase it confirms that the byte was untouched and that the unlock is still available for a following program. Lockout is entered in each of its three ways, each followed by a full correct sequence that must have no effect, and then by a reset. Randomly spaced unlock sequences carry random program writes, and the bench compares every result with an AND-model of the array.

// File: rtl/flash_ctl_pkg.sv
`timescale 1ns/1ps
package flash_ctl_pkg;
  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_HALF = 2'd1,
    KEY_OPEN = 2'd2,
    KEY_LOCK = 2'd3
  } key_st_e;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;
endpackage

// File: rtl/flash_key_fsm.sv
`timescale 1ns/1ps
module flash_key_fsm
  import flash_ctl_pkg::*;
#(
  parameter int          KEY_W      = 8,
  parameter logic [7:0]  KEY_FIRST  = 8'hA5,
  parameter logic [7:0]  KEY_SECOND = 8'hF1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_wdata_i,
  input  logic             consume_i,
  output logic             open_o
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_wr_i) begin
      unique case (st_q)
        KEY_IDLE: st_d = (key_wdata_i == KEY_W'(KEY_FIRST))  ? KEY_HALF : KEY_LOCK;
        KEY_HALF: st_d = (key_wdata_i == KEY_W'(KEY_SECOND)) ? KEY_OPEN : KEY_LOCK;
        default:  st_d = KEY_LOCK;
      endcase
    end else if (consume_i && st_q == KEY_OPEN) begin
      st_d = KEY_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KEY_IDLE;
    else         st_q <= st_d;
  end

  assign open_o = (st_q == KEY_OPEN);

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == KEY_LOCK |=> st_q == KEY_LOCK); // R3
  AST_OPEN_ONLY_FROM_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(st_q) == KEY_HALF); // R1
endmodule

// File: rtl/flash_op_seq.sv
`timescale 1ns/1ps
module flash_op_seq
  import flash_ctl_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 512,
  parameter int PROG_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] fl_rdata_i,
  output logic              busy_o,
  output logic              fl_we_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [DATA_W-1:0] fl_wdata_o
);
  localparam int PAGE_W  = $clog2(PAGE_BYTES);
  localparam int CNT_MAX = (PAGE_BYTES > PROG_CYCLES) ? PAGE_BYTES : PROG_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic              busy_q;
  op_kind_e          kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last;

  assign last = (kind_q == OP_ERASE) ? (cnt_q == CNT_W'(PAGE_BYTES - 1))
                                     : (cnt_q == CNT_W'(PROG_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      kind_q <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (last) busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      kind_q <= erase_i ? OP_ERASE : OP_PROG;
      addr_q <= addr_i;
      data_q <= data_i;
      cnt_q  <= '0;
    end
  end

  assign busy_o    = busy_q;
  assign fl_we_o   = busy_q && (kind_q == OP_ERASE || last);
  assign fl_addr_o = (kind_q == OP_ERASE) ? {addr_q[ADDR_W-1:PAGE_W], cnt_q[PAGE_W-1:0]}
                                          : addr_q;
  // program can only clear bits
  assign fl_wdata_o = (kind_q == OP_ERASE) ? {DATA_W{1'b1}} : (fl_rdata_i & data_q);

  AST_ADDR_STABLE_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) && kind_q == OP_PROG |-> $stable(fl_addr_o)); // R7
  AST_ERASE_IN_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) && kind_q == OP_ERASE
      |-> fl_addr_o[ADDR_W-1:PAGE_W] == $past(fl_addr_o[ADDR_W-1:PAGE_W])); // R8
endmodule

// File: rtl/flash_irq_hold.sv
`timescale 1ns/1ps
module flash_irq_hold #(
  parameter int N_IRQ = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic [N_IRQ-1:0] irq_i,
  output logic [N_IRQ-1:0] irq_o
);
  logic [N_IRQ-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= '0;
    else if (busy_i) pend_q <= pend_q | irq_i;
    else             pend_q <= '0;
  end

  assign irq_o = busy_i ? '0 : (irq_i | pend_q);

  AST_IRQ_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && (irq_i != '0) |=> (pend_q != '0)); // R12
  AST_IRQ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) && $past(pend_q != '0) |-> (irq_o != '0)); // R12
endmodule

// File: rtl/flash_wr_ctrl.sv
`timescale 1ns/1ps
module flash_wr_ctrl
  import flash_ctl_pkg::*;
#(
  parameter int         ADDR_W      = 15,
  parameter int         DATA_W      = 8,
  parameter int         PAGE_BYTES  = 512,
  parameter int         PROG_CYCLES = 8,
  parameter int         RSV_BASE    = 32'h7C00,
  parameter int         RSV_BYTES   = 1024,
  parameter int         N_IRQ       = 4,
  parameter logic [7:0] KEY_FIRST   = 8'hA5,
  parameter logic [7:0] KEY_SECOND  = 8'hF1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic [1:0]        ctl_wdata_i,
  output logic              wen_o,
  output logic              erase_sel_o,
  input  logic              key_wr_i,
  input  logic [7:0]        key_wdata_i,
  input  logic              cpu_wr_i,
  input  logic              cpu_rd_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic              vdd_mon_en_i,
  input  logic [DATA_W-1:0] fl_rdata_i,
  output logic              fl_we_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [DATA_W-1:0] fl_wdata_o,
  output logic              busy_o,
  output logic              rsv_err_o,
  output logic              flash_err_rst_o,
  input  logic [N_IRQ-1:0]  irq_i,
  output logic [N_IRQ-1:0]  irq_o
);
  localparam int AW1     = ADDR_W + 1;
  localparam int RSV_END = RSV_BASE + RSV_BYTES;

  logic wen_q, esel_q;
  logic key_open, busy;
  logic attempt, vdd_ok, cpu_in_rsv, fl_in_rsv, start, consume;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q  <= 1'b0;
      esel_q <= 1'b0;
    end else if (ctl_wr_i) begin
      wen_q  <= ctl_wdata_i[0];
      esel_q <= ctl_wdata_i[1];
    end
  end

  assign cpu_in_rsv = ({1'b0, cpu_addr_i} >= AW1'(RSV_BASE)) && ({1'b0, cpu_addr_i} < AW1'(RSV_END));
  assign fl_in_rsv  = ({1'b0, fl_addr_o}  >= AW1'(RSV_BASE)) && ({1'b0, fl_addr_o}  < AW1'(RSV_END));

  // flash-directed writes during busy are dropped entirely
  assign attempt = cpu_wr_i && wen_q && !busy;
  assign vdd_ok  = vdd_mon_en_i;
  assign consume = attempt && vdd_ok && key_open;
  assign start   = consume && !cpu_in_rsv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsv_err_o       <= 1'b0;
      flash_err_rst_o <= 1'b0;
    end else begin
      flash_err_rst_o <= attempt && !vdd_ok;
      rsv_err_o       <= attempt && vdd_ok && cpu_in_rsv;
    end
  end

  assign ram_we_o    = cpu_wr_i && !wen_q;
  assign ram_re_o    = cpu_rd_i;
  assign ram_addr_o  = cpu_addr_i;
  assign ram_wdata_o = cpu_wdata_i;

  flash_key_fsm #(
    .KEY_W      (8),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_key (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .key_wr_i    (key_wr_i),
    .key_wdata_i (key_wdata_i),
    .consume_i   (consume),
    .open_o      (key_open)
  );

  flash_op_seq #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PAGE_BYTES  (PAGE_BYTES),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .erase_i    (esel_q),
    .addr_i     (cpu_addr_i),
    .data_i     (cpu_wdata_i),
    .fl_rdata_i (fl_rdata_i),
    .busy_o     (busy),
    .fl_we_o    (fl_we_o),
    .fl_addr_o  (fl_addr_o),
    .fl_wdata_o (fl_wdata_o)
  );

  flash_irq_hold #(.N_IRQ(N_IRQ)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy),
    .irq_i  (irq_i),
    .irq_o  (irq_o)
  );

  assign busy_o      = busy;
  assign wen_o       = wen_q;
  assign erase_sel_o = esel_q;

  AST_START_KEYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(key_open)); // R1
  AST_START_VDD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(vdd_mon_en_i)); // R10
  AST_RSV_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_we_o |-> !fl_in_rsv); // R9
  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsv_err_o && flash_err_rst_o)); // R10
  AST_START_WEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wen_o)); // R5
endmodule

// File: tb/tb_flash_wr_ctrl.sv
`timescale 1ns/1ps
module tb_flash_wr_ctrl;
  localparam int PROG_N = 8;
  localparam int PAGE_N = 512;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctl_wr_i = 1'b0;
  logic [1:0]  ctl_wdata_i = '0;
  logic        wen_o, erase_sel_o;
  logic        key_wr_i = 1'b0;
  logic [7:0]  key_wdata_i = '0;
  logic        cpu_wr_i = 1'b0, cpu_rd_i = 1'b0;
  logic [14:0] cpu_addr_i = '0;
  logic [7:0]  cpu_wdata_i = '0;
  logic        ram_we_o, ram_re_o;
  logic [14:0] ram_addr_o;
  logic [7:0]  ram_wdata_o;
  logic        vdd_mon_en_i = 1'b1;
  logic [7:0]  fl_rdata_i;
  logic        fl_we_o;
  logic [14:0] fl_addr_o;
  logic [7:0]  fl_wdata_o;
  logic        busy_o, rsv_err_o, flash_err_rst_o;
  logic [3:0]  irq_i = '0;
  logic [3:0]  irq_o;

  int n_vec = 0, n_bad = 0, we_cnt = 0;
  logic [7:0] mem [0:4095];
  logic [7:0] exp_mem [0:4095];
  logic seen_rsv, seen_rst, seen_ram;

  always #2.5 clk = ~clk;

  flash_wr_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
    .wen_o(wen_o), .erase_sel_o(erase_sel_o), .key_wr_i(key_wr_i), .key_wdata_i(key_wdata_i),
    .cpu_wr_i(cpu_wr_i), .cpu_rd_i(cpu_rd_i), .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
    .ram_we_o(ram_we_o), .ram_re_o(ram_re_o), .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
    .vdd_mon_en_i(vdd_mon_en_i), .fl_rdata_i(fl_rdata_i), .fl_we_o(fl_we_o),
    .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .busy_o(busy_o), .rsv_err_o(rsv_err_o),
    .flash_err_rst_o(flash_err_rst_o), .irq_i(irq_i), .irq_o(irq_o)
  );

  assign fl_rdata_i = mem[fl_addr_o[11:0]];
  always @(posedge clk) if (fl_we_o) begin
    mem[fl_addr_o[11:0]] <= fl_wdata_o;
    we_cnt <= we_cnt + 1;
  end

  function automatic logic [7:0] prog_model(logic [7:0] old_b, logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    idle(2); rst_ni = 1'b1;
  endtask

  task automatic key_wr(logic [7:0] v);
    @(negedge clk); key_wr_i = 1'b1; key_wdata_i = v;
    @(negedge clk); key_wr_i = 1'b0;
  endtask

  task automatic ctl_wr(logic wen, logic esel);
    @(negedge clk); ctl_wr_i = 1'b1; ctl_wdata_i = {esel, wen};
    @(negedge clk); ctl_wr_i = 1'b0;
  endtask

  task automatic cpu_wr(logic [14:0] a, logic [7:0] d);
    @(negedge clk); cpu_wr_i = 1'b1; cpu_addr_i = a; cpu_wdata_i = d;
    #1 seen_ram = ram_we_o;
    @(posedge clk); #1;
    seen_rsv = rsv_err_o; seen_rst = flash_err_rst_o;
    @(negedge clk); cpu_wr_i = 1'b0;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy_o && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic prog_op(logic [14:0] a, logic [7:0] d, int gap);
    int n;
    key_wr(8'hA5); idle(gap); key_wr(8'hF1);
    cpu_wr(a, d);
    wait_busy(n);
    exp_mem[a[11:0]] = prog_model(exp_mem[a[11:0]], d);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int n, w0, bad, seed;
    logic [14:0] a;
    logic [7:0] d;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 4096; i++) begin mem[i] = 8'hFF; exp_mem[i] = 8'hFF; end
    do_reset();

    // reset state
    check(wen_o == 0 && erase_sel_o == 0, "R4 reset ctl", {wen_o, erase_sel_o}, 0);
    check(busy_o == 0 && irq_o == 0, "R11 reset busy", busy_o, 0);

    // RAM routing with write-enable low
    cpu_wr(15'h0123, 8'h5A);
    check(seen_ram == 1, "R5 ram write when wen=0", seen_ram, 1);
    check(mem[12'h123] == 8'hFF && we_cnt == 0, "R5 flash untouched", mem[12'h123], 8'hFF);

    ctl_wr(1'b1, 1'b0);
    check(wen_o == 1 && erase_sel_o == 0, "R4 ctl bits", {erase_sel_o, wen_o}, 1);
    @(negedge clk); cpu_rd_i = 1'b1; #1;
    check(ram_re_o == 1, "R6 read goes to RAM", ram_re_o, 1);
    @(negedge clk); cpu_rd_i = 1'b0;

    // write without unlock
    cpu_wr(15'h0010, 8'h00);
    check(seen_ram == 0, "R5 no ram write when wen=1", seen_ram, 0);
    idle(PROG_N + 2);
    check(mem[12'h010] == 8'hFF && busy_o == 0, "R1 no unlock no change", mem[12'h010], 8'hFF);

    // keyed program with busy length
    key_wr(8'hA5); key_wr(8'hF1);
    cpu_wr(15'h0020, 8'h3C);
    wait_busy(n);
    exp_mem[12'h020] = prog_model(exp_mem[12'h020], 8'h3C);
    check(n == PROG_N, "R11 program busy length", n, PROG_N);
    check(mem[12'h020] == exp_mem[12'h020], "R7 program value", mem[12'h020], exp_mem[12'h020]);
    // AND behaviour: cannot set bits
    prog_op(15'h0020, 8'hF0, 0);
    check(mem[12'h020] == 8'h30, "R7 program only clears", mem[12'h020], 8'h30);
    check(wen_o == 1, "R4 wen persists", wen_o, 1);

    // key consumed
    cpu_wr(15'h0020, 8'h00);
    idle(PROG_N + 2);
    check(mem[12'h020] == 8'h30, "R2 key consumed", mem[12'h020], 8'h30);

    // long gap between keys
    prog_op(15'h0030, 8'h81, 300);
    check(mem[12'h030] == 8'h81, "R1 key gap", mem[12'h030], 8'h81);

    // interrupts held during busy
    @(negedge clk); irq_i = 4'b0001; #1;
    check(irq_o == 4'b0001, "R12 pass-through idle", irq_o, 1);
    irq_i = 4'b0000;
    key_wr(8'hA5); key_wr(8'hF1);
    cpu_wr(15'h0040, 8'h77);
    irq_i = 4'b0100; #1;
    check(irq_o == 4'b0000, "R12 masked while busy", irq_o, 0);
    @(negedge clk); irq_i = 4'b0000;
    wait_busy(n);
    exp_mem[12'h040] = 8'h77;
    check(irq_o == 4'b0100, "R12 released after busy", irq_o, 4);
    @(negedge clk);
    check(irq_o == 4'b0000, "R12 single cycle", irq_o, 0);

    // erase page 0x0400..0x05FF
    for (int i = 12'h400; i < 12'h600; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    mem[12'h3FF] = 8'h11; exp_mem[12'h3FF] = 8'h11;
    mem[12'h600] = 8'h22; exp_mem[12'h600] = 8'h22;
    ctl_wr(1'b1, 1'b1);
    key_wr(8'hA5); key_wr(8'hF1);
    w0 = we_cnt;
    cpu_wr(15'h04A7, 8'h00);
    wait_busy(n);
    check(n == PAGE_N, "R8 erase busy length", n, PAGE_N);
    check(we_cnt - w0 == PAGE_N, "R8 erase write count", we_cnt - w0, PAGE_N);
    bad = 0;
    for (int i = 12'h400; i < 12'h600; i++) if (mem[i] != 8'hFF) bad++;
    check(bad == 0, "R8 page erased", bad, 0);
    check(mem[12'h3FF] == 8'h11 && mem[12'h600] == 8'h22, "R8 neighbours kept", mem[12'h600], 8'h22);
    for (int i = 12'h400; i < 12'h600; i++) exp_mem[i] = 8'hFF;

    // write during busy ignored, key not consumed
    key_wr(8'hA5); key_wr(8'hF1);
    cpu_wr(15'h0401, 8'h00);
    ctl_wr(1'b1, 1'b0);
    key_wr(8'hA5); key_wr(8'hF1);
    cpu_wr(15'h0800, 8'h0F);
    wait_busy(n);
    check(mem[12'h800] == 8'hFF, "R11 write while busy ignored", mem[12'h800], 8'hFF);
    cpu_wr(15'h0800, 8'h0F);
    wait_busy(n);
    exp_mem[12'h800] = 8'h0F;
    check(mem[12'h800] == 8'h0F, "R11 key survives busy write", mem[12'h800], 8'h0F);

    // reserved range
    key_wr(8'hA5); key_wr(8'hF1);
    w0 = we_cnt;
    cpu_wr(15'h7C10, 8'h00);
    check(seen_rsv == 1 && seen_rst == 0, "R9 reserved flagged", seen_rsv, 1);
    @(negedge clk);
    check(rsv_err_o == 0, "R9 single pulse", rsv_err_o, 0);
    cpu_wr(15'h0050, 8'h00);
    idle(PROG_N + 2);
    check(we_cnt == w0 && mem[12'h050] == 8'hFF, "R2 reserved consumes key", we_cnt - w0, 0);

    // supply monitor low
    key_wr(8'hA5); key_wr(8'hF1);
    vdd_mon_en_i = 1'b0;
    cpu_wr(15'h7C20, 8'h00);
    check(seen_rst == 1 && seen_rsv == 0, "R10 reset request", seen_rst, 1);
    vdd_mon_en_i = 1'b1;
    cpu_wr(15'h0060, 8'h06);
    wait_busy(n);
    exp_mem[12'h060] = 8'h06;
    check(mem[12'h060] == 8'h06 && we_cnt == w0 + 1, "R10 no write, key kept", mem[12'h060], 8'h06);

    // lockout: wrong order
    key_wr(8'hF1); key_wr(8'hA5); key_wr(8'hF1);
    cpu_wr(15'h0070, 8'h00);
    idle(PROG_N + 2);
    check(mem[12'h070] == 8'hFF && busy_o == 0, "R3 wrong order locks", mem[12'h070], 8'hFF);
    do_reset();
    ctl_wr(1'b1, 1'b0);
    // lockout: wrong second key
    key_wr(8'hA5); key_wr(8'h00); key_wr(8'hA5); key_wr(8'hF1);
    cpu_wr(15'h0070, 8'h00);
    idle(PROG_N + 2);
    check(mem[12'h070] == 8'hFF, "R3 wrong value locks", mem[12'h070], 8'hFF);
    do_reset();
    ctl_wr(1'b1, 1'b0);
    // lockout: key write while open
    key_wr(8'hA5); key_wr(8'hF1); key_wr(8'hA5);
    cpu_wr(15'h0070, 8'h00);
    idle(PROG_N + 2);
    check(mem[12'h070] == 8'hFF, "R3 extra key locks", mem[12'h070], 8'hFF);
    do_reset();
    ctl_wr(1'b1, 1'b0);
    prog_op(15'h0070, 8'h70, 1);
    check(mem[12'h070] == 8'h70, "R3 reset clears lockout", mem[12'h070], 8'h70);

    // random programs
    for (int k = 0; k < 40; k++) begin
      a = {3'b000, 12'($urandom)};
      if (a[11:9] == 3'b010) a[11] = 1'b1;
      d = 8'($urandom);
      prog_op(a, d, int'($urandom % 12));
      check(mem[a[11:0]] == exp_mem[a[11:0]], "R7 random program", mem[a[11:0]], exp_mem[a[11:0]]);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule